// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block derives all internal timing of a small 8-bit processor from a single oscillator clock. The oscillator is halved first, which gives a state tick every second oscillator cycle. Six states make one machine cycle of 12 oscillator periods. From this the block produces clock enables for the CPU and for the peripherals, a machine-cycle strobe and an address-latch strobe that runs at one sixth of the oscillator rate.

The block also qualifies the external reset pin. The pin is synchronised and passed through a glitch filter. It is then sampled once per machine cycle at a fixed state. The internal reset asserts only after two consecutive samples are high, and it releases at the first low sample.

A power-control byte written by the core selects one of two low-power modes:
- **Idle** stops the CPU enable only, and is left on a pending interrupt or on reset.
- **Power-down** stops every enable, including the oscillator-run enable, and is left only by reset. A rising, filtered reset pin restarts the oscillator so that the reset can be qualified.

The `rst_i` input is the chip-level initialisation reset. It is separate from the reset pin.

Top module: `pwr_clkrst_ctrl`

## Requirements
- R1: While in run mode, `cpu_clk_en_o` and `per_clk_en_o` are each high on exactly every second oscillator cycle (60 of any 120 consecutive cycles).
- R2: While the oscillator runs, `mc_strobe_o` is high for one cycle in every 12 oscillator cycles and is never high on two adjacent cycles.
- R3: `ale_strobe_o` is high once in every 6 oscillator cycles, and it is high in every cycle in which `mc_strobe_o` is high.
- R4: A high pulse on `rst_pin_i` lasting fewer than 4 oscillator cycles never asserts `int_rst_o`.
- R5: A high level on `rst_pin_i` lasting 12 cycles or less (with at least 16 low cycles before it) never asserts `int_rst_o`. A held high asserts `int_rst_o` between 13 and 32 cycles after the rising edge. After the pin falls, `int_rst_o` clears within 30 cycles.
- R6: Writing a byte with bit 0 set and bit 1 clear enters idle. In idle, `cpu_clk_en_o` stays low while `per_clk_en_o` keeps its 1-in-2 rate.
- R7: In idle, `irq_pend_i` high clears bit 0 of `pcon_o` at the next edge, and the CPU enable resumes. An internal reset also leaves idle.
- R8: Writing a byte with bit 1 set enters power-down. While the reset pin is low, `cpu_clk_en_o`, `per_clk_en_o`, `mc_strobe_o`, `ale_strobe_o` and `osc_run_en_o` all stay low.
- R9: Power-down ignores `irq_pend_i` and register writes, and `pcon_o` keeps bit 1. Holding the reset pin high restarts `osc_run_en_o`, then asserts `int_rst_o`, and this returns the block to run mode.
- R10: While `int_rst_o` is high, `pcon_o` is cleared at each edge except bit 4, which keeps its value. Writes are ignored while `int_rst_o` is high.
- R11: A write with both bit 0 and bit 1 set enters power-down, not idle.
- R12: In run mode, a write with `pcon_we_i` high loads the full byte into `pcon_o` at the next edge. In idle, writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Chip-level synchronous initialisation reset, active high |
| rst_pin_i | input | 1 | Raw external reset pin, active high, asynchronous |
| pcon_we_i | input | 1 | Power-control byte write strobe from the core |
| pcon_wdata_i | input | 8 | Power-control write data (bit 0 idle, bit 1 power-down, bit 4 kept through reset) |
| irq_pend_i | input | 1 | Pending-interrupt flag |
| cpu_clk_en_o | output | 1 | CPU clock enable, one pulse per divided-clock state |
| per_clk_en_o | output | 1 | Peripheral and interrupt clock enable |
| osc_run_en_o | output | 1 | Oscillator-run enable |
| mc_strobe_o | output | 1 | Machine-cycle strobe |
| ale_strobe_o | output | 1 | Address-latch strobe |
| int_rst_o | output | 1 | Qualified synchronous internal reset |
| pcon_o | output | 8 | Current power-control byte |

## Verification
The bench builds the block with its default parameters: six states per machine cycle, two address-latch strobes per machine cycle, a sample at state 4, a four-cycle glitch filter and a two-sample hold. These values keep a machine cycle at 12 oscillator periods. Every filter, hold and exit window therefore spans only tens of cycles, so the bench can run many random glitch widths, short reset holds and idle durations. It also drives each mode transition, including the reset-driven wake from power-down.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    localparam int PCON_W           = 8;
    localparam int IDL_BIT          = 0;
    localparam int PD_BIT           = 1;
    localparam int KEEP_BIT         = 4;

    localparam int DEF_STATES_MC    = 6;
    localparam int DEF_ALE_PER_MC   = 2;
    localparam int DEF_SAMPLE_STATE = 4;
    localparam int DEF_GLITCH_LEN   = 4;
    localparam int DEF_HOLD_MC      = 2;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2
    } pwr_mode_e;

    typedef struct packed {
        logic tick;
        logic mc;
        logic ale;
        logic sample;
    } phase_strb_t;

    // Power-down outranks idle when both request bits are set.
    function automatic pwr_mode_e mode_of(input logic idl, input logic pd);
        if (pd)
            return PM_PDOWN;
        else if (idl)
            return PM_IDLE;
        return PM_RUN;
    endfunction

endpackage

// File: rtl/pwr_phase_gen.sv
module pwr_phase_gen
    import pwrctl_pkg::*;
#(
    parameter int STATES_MC    = DEF_STATES_MC,
    parameter int ALE_PER_MC   = DEF_ALE_PER_MC,
    parameter int SAMPLE_STATE = DEF_SAMPLE_STATE
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        run_en_i,
    output phase_strb_t strb_o
);
    localparam int SW       = (STATES_MC > 2) ? $clog2(STATES_MC) : 1;
    localparam int ALE_SPAN = (ALE_PER_MC > 0) ? (STATES_MC / ALE_PER_MC) : STATES_MC;
    localparam logic [SW-1:0] ST_LAST = SW'(STATES_MC - 1);
    localparam logic [SW-1:0] ST_SMP  = SW'(SAMPLE_STATE);

    logic          half_q;
    logic [SW-1:0] st_q;
    logic          tick, mc, ale;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            half_q <= 1'b0;
            st_q   <= '0;
        end else if (run_en_i) begin
            half_q <= ~half_q;
            if (half_q)
                st_q <= (st_q == ST_LAST) ? '0 : st_q + 1'b1;
        end
    end

    assign tick = run_en_i & half_q;
    assign mc   = tick && (st_q == ST_LAST);

    generate
        if (ALE_PER_MC <= 1) begin : g_ale_mc
            assign ale = mc;
        end else begin : g_ale_div
            always_comb ale = tick && ((int'(st_q) % ALE_SPAN) == ALE_SPAN - 1);
        end
    endgenerate

    assign strb_o = '{tick: tick, mc: mc, ale: ale, sample: tick && (st_q == ST_SMP)};

endmodule

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual
    import pwrctl_pkg::*;
#(
    parameter int GLITCH_LEN = DEF_GLITCH_LEN,
    parameter int HOLD_MC    = DEF_HOLD_MC
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    input  logic sample_i,
    output logic filt_o,
    output logic int_rst_o
);
    localparam int GCW = $clog2(GLITCH_LEN + 1);
    localparam int HCW = $clog2(HOLD_MC + 1);
    localparam logic [GCW-1:0] G_LAST = GCW'(GLITCH_LEN - 1);
    localparam logic [HCW-1:0] H_MAX  = HCW'(HOLD_MC);
    localparam logic [HCW-1:0] H_TRIG = HCW'(HOLD_MC - 1);

    logic [1:0]     sync_q;
    logic [GCW-1:0] gcnt_q;
    logic           filt_q;
    logic [HCW-1:0] hold_q;
    logic           irst_q;

    // Two-flop synchroniser, then a level filter needing GLITCH_LEN stable cycles.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
            gcnt_q <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            if (sync_q[1] != filt_q) begin
                if (gcnt_q == G_LAST) begin
                    filt_q <= sync_q[1];
                    gcnt_q <= '0;
                end else begin
                    gcnt_q <= gcnt_q + 1'b1;
                end
            end else begin
                gcnt_q <= '0;
            end
        end
    end

    // Once-per-machine-cycle sampling with consecutive-high counting.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q <= '0;
            irst_q <= 1'b0;
        end else if (sample_i) begin
            if (filt_q) begin
                if (hold_q != H_MAX)
                    hold_q <= hold_q + 1'b1;
                irst_q <= (hold_q >= H_TRIG);
            end else begin
                hold_q <= '0;
                irst_q <= 1'b0;
            end
        end
    end

    assign filt_o    = filt_q;
    assign int_rst_o = irst_q;

endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
    import pwrctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              int_rst_i,
    input  logic              we_i,
    input  logic [PCON_W-1:0] wdata_i,
    input  logic              irq_i,
    output logic [PCON_W-1:0] pcon_o,
    output pwr_mode_e         mode_o
);
    localparam logic [PCON_W-1:0] KEEP_MASK = PCON_W'(1) << KEEP_BIT;

    logic [PCON_W-1:0] pcon_q;
    pwr_mode_e         mode;

    assign mode = mode_of(pcon_q[IDL_BIT], pcon_q[PD_BIT]);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pcon_q <= '0;
        end else if (int_rst_i) begin
            pcon_q <= pcon_q & KEEP_MASK;
        end else begin
            unique case (mode)
                PM_RUN:   if (we_i) pcon_q <= wdata_i;
                PM_IDLE:  if (irq_i) pcon_q[IDL_BIT] <= 1'b0;
                default:  pcon_q <= pcon_q;
            endcase
        end
    end

    assign pcon_o = pcon_q;
    assign mode_o = mode;

endmodule

// File: rtl/pwr_clkrst_ctrl.sv
module pwr_clkrst_ctrl
    import pwrctl_pkg::*;
#(
    parameter int STATES_MC    = DEF_STATES_MC,
    parameter int ALE_PER_MC   = DEF_ALE_PER_MC,
    parameter int SAMPLE_STATE = DEF_SAMPLE_STATE,
    parameter int GLITCH_LEN   = DEF_GLITCH_LEN,
    parameter int HOLD_MC      = DEF_HOLD_MC
) (
    input  logic       osc_clk_i,
    input  logic       rst_i,
    input  logic       rst_pin_i,
    input  logic       pcon_we_i,
    input  logic [7:0] pcon_wdata_i,
    input  logic       irq_pend_i,
    output logic       cpu_clk_en_o,
    output logic       per_clk_en_o,
    output logic       osc_run_en_o,
    output logic       mc_strobe_o,
    output logic       ale_strobe_o,
    output logic       int_rst_o,
    output logic [7:0] pcon_o
);
    phase_strb_t strb;
    pwr_mode_e   mode;
    logic        pin_filt;
    logic        irst;
    logic        osc_run;

    // The filtered pin restarts a stopped oscillator so the reset can be qualified.
    assign osc_run = (mode != PM_PDOWN) | pin_filt;

    pwr_phase_gen #(
        .STATES_MC   (STATES_MC),
        .ALE_PER_MC  (ALE_PER_MC),
        .SAMPLE_STATE(SAMPLE_STATE)
    ) phase_i (
        .clk_i   (osc_clk_i),
        .rst_i   (rst_i),
        .run_en_i(osc_run),
        .strb_o  (strb)
    );

    pwr_rst_qual #(
        .GLITCH_LEN(GLITCH_LEN),
        .HOLD_MC   (HOLD_MC)
    ) rstq_i (
        .clk_i    (osc_clk_i),
        .rst_i    (rst_i),
        .pin_i    (rst_pin_i),
        .sample_i (strb.sample),
        .filt_o   (pin_filt),
        .int_rst_o(irst)
    );

    pwr_mode_reg mode_i (
        .clk_i    (osc_clk_i),
        .rst_i    (rst_i),
        .int_rst_i(irst),
        .we_i     (pcon_we_i),
        .wdata_i  (pcon_wdata_i),
        .irq_i    (irq_pend_i),
        .pcon_o   (pcon_o),
        .mode_o   (mode)
    );

    assign cpu_clk_en_o = strb.tick & (mode == PM_RUN);
    assign per_clk_en_o = strb.tick & (mode != PM_PDOWN);
    assign osc_run_en_o = osc_run;
    assign mc_strobe_o  = strb.mc;
    assign ale_strobe_o = strb.ale;
    assign int_rst_o    = irst;

endmodule

// File: rtl/pwr_clkrst_chk.sv
module pwr_clkrst_chk
    import pwrctl_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       irq_i,
    input logic       cpu_en_i,
    input logic       per_en_i,
    input logic       osc_run_i,
    input logic       mc_i,
    input logic       ale_i,
    input logic       int_rst_i,
    input logic [7:0] pcon_i
);
    localparam logic [7:0] NOT_KEEP = ~(8'(1) << KEEP_BIT);

    AST_CPU_EN_RUN_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        cpu_en_i |-> (!pcon_i[IDL_BIT] && !pcon_i[PD_BIT]));                       // R6
    AST_PD_ENABLES_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        pcon_i[PD_BIT] |-> (!cpu_en_i && !per_en_i));                              // R8
    AST_PD_STOPPED_NO_MC: assert property (@(posedge clk_i) disable iff (rst_i)
        (pcon_i[PD_BIT] && !osc_run_i) |-> (!mc_i && !ale_i));                     // R8
    AST_ALE_WITH_MC: assert property (@(posedge clk_i) disable iff (rst_i)
        mc_i |-> ale_i);                                                           // R3
    AST_MC_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        mc_i |=> !mc_i);                                                           // R2
    AST_RST_CLEARS_PCON: assert property (@(posedge clk_i) disable iff (rst_i)
        int_rst_i |=> ((pcon_i & NOT_KEEP) == 8'h00));                             // R10
    AST_IDLE_IRQ_EXIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (pcon_i[IDL_BIT] && !pcon_i[PD_BIT] && irq_i && !int_rst_i) |=> !pcon_i[IDL_BIT]); // R7
    AST_PD_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (pcon_i[PD_BIT] && !int_rst_i) |=> pcon_i[PD_BIT]);                        // R9

endmodule

bind pwr_clkrst_ctrl pwr_clkrst_chk chk_i (
    .clk_i    (osc_clk_i),
    .rst_i    (rst_i),
    .irq_i    (irq_pend_i),
    .cpu_en_i (cpu_clk_en_o),
    .per_en_i (per_clk_en_o),
    .osc_run_i(osc_run_en_o),
    .mc_i     (mc_strobe_o),
    .ale_i    (ale_strobe_o),
    .int_rst_i(int_rst_o),
    .pcon_i   (pcon_o)
);

// File: tb/pwr_clkrst_ctrl_tb_top.sv
module pwr_clkrst_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       irq = 1'b0;
    logic       cpu_en, per_en, osc_run, mc, ale, irst;
    logic [7:0] pcon;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int unsigned seed = 32'd4711;

    always #5 clk = ~clk;

    pwr_clkrst_ctrl dut_i (
        .osc_clk_i   (clk),
        .rst_i       (rst),
        .rst_pin_i   (pin),
        .pcon_we_i   (we),
        .pcon_wdata_i(wdata),
        .irq_pend_i  (irq),
        .cpu_clk_en_o(cpu_en),
        .per_clk_en_o(per_en),
        .osc_run_en_o(osc_run),
        .mc_strobe_o (mc),
        .ale_strobe_o(ale),
        .int_rst_o   (irst),
        .pcon_o      (pcon)
    );

    function automatic int exp_ticks(input int n); return n / 2;  endfunction
    function automatic int exp_mc(input int n);    return n / 12; endfunction
    function automatic int exp_ale(input int n);   return n / 6;  endfunction
    function automatic logic [7:0] exp_after_rst(input logic [7:0] v); return v & 8'h10; endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic count_win(input int n, output int c_cpu, output int c_per, output int c_mc,
                             output int c_ale, output int c_osc, output int c_misal);
        c_cpu = 0; c_per = 0; c_mc = 0; c_ale = 0; c_osc = 0; c_misal = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c_cpu += int'(cpu_en); c_per += int'(per_en); c_mc += int'(mc);
            c_ale += int'(ale); c_osc += int'(osc_run);
            if (mc && !ale) c_misal++;
        end
    endtask

    task automatic write_pcon(input logic [7:0] v);
        we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic pulse_irq();
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    // Raises the pin until the internal reset is seen; returns the cycle count.
    task automatic assert_reset(output int lat);
        lat = -1;
        pin = 1'b1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (irst && lat < 0) lat = i;
            if (lat >= 0) break;
        end
    endtask

    task automatic release_reset(output int lat);
        lat = -1;
        pin = 1'b0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (!irst) begin lat = i; break; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cc, cp, cm, ca, co, cx, lat, seen;
        logic [7:0] v;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(irst == 1'b0 && pcon == 8'h00 && osc_run == 1'b1, "R10 reset state",
              {irst, osc_run, pcon}, 10'h100);

        count_win(120, cc, cp, cm, ca, co, cx);
        check(cc == exp_ticks(120), "R1 cpu enable rate", cc, exp_ticks(120));
        check(cp == exp_ticks(120), "R1 peripheral enable rate", cp, exp_ticks(120));
        check(cm == exp_mc(120), "R2 machine-cycle strobe rate", cm, exp_mc(120));
        check(ca == exp_ale(120), "R3 address-latch strobe rate", ca, exp_ale(120));
        check(cx == 0, "R3 strobe alignment", cx, 0);

        // R4: random short glitches
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            int w = int'($urandom_range(3, 1));
            int g = int'($urandom_range(20, 8));
            pin = 1'b1;
            repeat (w) @(negedge clk);
            pin = 1'b0;
            for (int i = 0; i < g; i++) begin @(negedge clk); seen += int'(irst); end
        end
        check(seen == 0, "R4 glitches rejected", seen, 0);

        // R5: short holds of at most one machine cycle
        seen = 0;
        for (int k = 0; k < 15; k++) begin
            int w = int'($urandom_range(12, 5));
            int g = int'($urandom_range(30, 16));
            pin = 1'b1;
            for (int i = 0; i < w; i++) begin @(negedge clk); seen += int'(irst); end
            pin = 1'b0;
            for (int i = 0; i < g; i++) begin @(negedge clk); seen += int'(irst); end
        end
        check(seen == 0, "R5 short hold rejected", seen, 0);

        assert_reset(lat);
        check(lat >= 13 && lat <= 32, "R5 reset latency", lat, 13);
        release_reset(lat);
        check(lat > 0 && lat <= 30, "R5 reset release", lat, 30);

        // R12 / R10: write, then reset keeps bit 4 only
        write_pcon(8'hDC);
        check(pcon == 8'hDC, "R12 full-byte write", pcon, 8'hDC);
        assert_reset(lat);
        @(negedge clk);
        check(pcon == exp_after_rst(8'hDC), "R10 keep bit 4", pcon, exp_after_rst(8'hDC));
        write_pcon(8'h01);
        check(pcon == 8'h10, "R10 write ignored in reset", pcon, 8'h10);
        release_reset(lat);
        for (int k = 0; k < 4; k++) begin
            v = 8'($urandom()) & 8'hFC;
            write_pcon(v);
            assert_reset(lat);
            @(negedge clk);
            check(pcon == exp_after_rst(v), "R10 random byte through reset", pcon, exp_after_rst(v));
            release_reset(lat);
        end

        // R6 / R7 / R12: idle entry and interrupt exit
        for (int k = 0; k < 5; k++) begin
            int n = 12 * int'($urandom_range(6, 2));
            write_pcon(8'h01);
            count_win(n, cc, cp, cm, ca, co, cx);
            check(cc == 0, "R6 cpu stopped in idle", cc, 0);
            check(cp == exp_ticks(n), "R6 peripheral runs in idle", cp, exp_ticks(n));
            if (k == 0) begin
                write_pcon(8'h00);
                check(pcon == 8'h01, "R12 write ignored in idle", pcon, 8'h01);
            end
            pulse_irq();
            check(pcon == 8'h00, "R7 interrupt clears idle", pcon, 8'h00);
            count_win(24, cc, cp, cm, ca, co, cx);
            check(cc == exp_ticks(24), "R7 cpu resumes", cc, exp_ticks(24));
        end

        // R7: reset leaves idle
        write_pcon(8'h11);
        assert_reset(lat);
        @(negedge clk);
        check(pcon == 8'h10, "R7 reset clears idle", pcon, 8'h10);
        release_reset(lat);
        count_win(24, cc, cp, cm, ca, co, cx);
        check(cc == exp_ticks(24), "R7 cpu runs after reset exit", cc, exp_ticks(24));

        // R8 / R9: power-down
        write_pcon(8'h02);
        count_win(48, cc, cp, cm, ca, co, cx);
        check(cc + cp + cm + ca == 0, "R8 all strobes stopped", cc + cp + cm + ca, 0);
        check(co == 0, "R8 oscillator stopped", co, 0);
        pulse_irq();
        repeat (3) @(negedge clk);
        check(pcon == 8'h02, "R9 interrupt ignored in power-down", pcon, 8'h02);
        write_pcon(8'h00);
        check(pcon == 8'h02, "R9 write ignored in power-down", pcon, 8'h02);
        check(osc_run == 1'b0, "R9 oscillator still stopped", osc_run, 0);
        assert_reset(lat);
        check(lat > 0 && lat <= 40, "R9 reset wakes power-down", lat, 40);
        check(osc_run == 1'b1, "R9 oscillator restarted", osc_run, 1);
        @(negedge clk);
        check(pcon == 8'h00, "R9 power-down cleared", pcon, 8'h00);
        release_reset(lat);
        count_win(24, cc, cp, cm, ca, co, cx);
        check(cc == exp_ticks(24) && cm == exp_mc(24), "R9 run resumes", cc, exp_ticks(24));

        // R11: both bits
        write_pcon(8'h03);
        count_win(24, cc, cp, cm, ca, co, cx);
        check(cp == 0 && co == 0, "R11 both bits give power-down", cp + co, 0);
        pulse_irq();
        check(pcon == 8'h03, "R11 interrupt does not exit", pcon, 8'h03);
        assert_reset(lat);
        release_reset(lat);
        check(pcon == 8'h00, "R11 reset exit", pcon, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule